// File: doc/BRIEF.md
# Row-Change Precharge Access Controller

This controller sits between a host and a 128K x 16 word memory array. It watches an active-low enable, a 17-bit word address and read/write strobes, and it decides per access whether the array row has to be closed and reopened. Address bits [16:2] select the row. Bits [1:0] select a word within that row.

An access that stays within the open row is served as a short page access. A new row first costs a precharge and then a row open. Raising the enable closes the row, but only once the enable has stayed high for the full precharge time. The block drops `ready` while it is busy. It raises `rd_valid` for one cycle when read data from the array is valid at `arr_addr`. For a write it raises `arr_we` for one cycle, and the array stores the host's data at `arr_addr` on the following edge. All delays are parameters counted in clock cycles: precharge 4, row open 6 and page access 2 by default.

Top module: `row_precharge_ctrl`

## Requirements
- R1: After reset no row is open, `ready` is 1, and `rd_valid` and `arr_we` are 0.
- R2: With no row open and `ready` high, a strobe sampled with `ce_n` low opens the row. The result is due ACC_CYC clock edges after the sampling edge.
- R3: When `ce_n` is sampled high while a row is open, `ready` goes low after that edge. It returns high after PRE_CYC consecutive edges that sample `ce_n` high, and the row is then closed.
- R4: If `ce_n` goes low before PRE_CYC consecutive high samples, the precharge does not complete. `ready` stays low until `ce_n` has again been high for PRE_CYC consecutive edges.
- R5: While `ce_n` is low and a row is open, any difference in `addr[16:2]` from the open row drops `ready` on the next edge. The row is precharged and the new row is opened, so the result is due PRE_CYC+ACC_CYC edges after the sampling edge.
- R6: A read whose `addr[16:2]` matches the open row is a page access. `rd_valid` is due PAGE_CYC edges after the sampling edge, with no precharge.
- R7: A write (`wr`=1, `rd`=0) follows the same latency rules as a read. It produces a one-cycle `arr_we` at the latched address and no `rd_valid`. If `rd` and `wr` are both high, the access is a read.
- R8: Strobes sampled while `ready` is low are ignored and produce no extra result.
- R9: `rd_valid` lasts exactly one cycle. While it is high, `arr_addr` holds the address of that access, so the array returns that word's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low enable; high requests a precharge |
| addr | input | 17 | Word address; [16:2] row, [1:0] column |
| rd | input | 1 | Read strobe, sampled when `ready` is high |
| wr | input | 1 | Write strobe, sampled when `ready` is high |
| ready | output | 1 | High when a new access can be accepted |
| rd_valid | output | 1 | One-cycle pulse: read data valid at `arr_addr` |
| arr_we | output | 1 | One-cycle array write enable |
| arr_addr | output | 17 | Latched address driven to the array |

## Verification
A result is due ACC_CYC edges after the request edge when no row is open. It is due PAGE_CYC edges after a same-row request, and PRE_CYC+ACC_CYC edges after a row change. The driver records each item with that due cycle, using its own model of which row is open. The monitor samples on the falling edge and compares the cycle of each `rd_valid` or `arr_we` with the due cycle. An output that comes early, late or unrequested is flagged. The enable-driven precharge is checked at the falling edges just before and just after the PRE_CYC-th high sample.

// File: rtl/row_precharge_ctrl.sv
module row_precharge_ctrl #(
  parameter int AW       = 17,
  parameter int ROW_LSB  = 2,
  parameter int PRE_CYC  = 4,
  parameter int ACC_CYC  = 6,
  parameter int PAGE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          ready,
  output logic          rd_valid,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr
);
  localparam int MAXC = (PRE_CYC > ACC_CYC) ? ((PRE_CYC > PAGE_CYC) ? PRE_CYC : PAGE_CYC)
                                            : ((ACC_CYC > PAGE_CYC) ? ACC_CYC : PAGE_CYC);
  localparam int CW = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {S_CLOSED, S_PRE, S_OPEN, S_ACT, S_PAGE} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic                 ce_pre;
  logic [1:0]           op;
  logic [AW-1:0]        lat_q;
  logic [AW-1:ROW_LSB]  row_q;
  logic                 row_closed, active, row_hit;

  assign row_closed = (st == S_CLOSED);
  assign active     = (st == S_ACT);
  assign row_hit    = (addr[AW-1:ROW_LSB] == row_q);
  assign ready      = row_closed | active;
  assign arr_addr   = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_CLOSED;
      cnt      <= '0;
      ce_pre   <= 1'b0;
      op       <= 2'b00;
      lat_q    <= '0;
      row_q    <= '0;
      rd_valid <= 1'b0;
      arr_we   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      arr_we   <= 1'b0;
      case (st)
        S_CLOSED: if (!ce_n) begin
          lat_q <= addr;
          op    <= {rd, wr};
          cnt   <= '0;
          st    <= S_OPEN;
        end
        S_ACT: begin
          if (ce_n) begin
            st     <= S_PRE;
            ce_pre <= 1'b1;
            cnt    <= CW'(1);
          end else if (!row_hit) begin
            st     <= S_PRE;
            ce_pre <= 1'b0;
            cnt    <= '0;
            lat_q  <= addr;
            op     <= {rd, wr};
          end else if (rd || wr) begin
            st    <= S_PAGE;
            cnt   <= '0;
            lat_q <= addr;
            op    <= {rd, wr};
          end
        end
        S_PRE: begin
          if (ce_pre) begin
            if (!ce_n)                         cnt <= '0;
            else if (cnt == CW'(PRE_CYC - 1))  st  <= S_CLOSED;
            else                               cnt <= cnt + 1'b1;
          end else if (ce_n) begin
            ce_pre <= 1'b1;
            cnt    <= CW'(1);
          end else if (cnt == CW'(PRE_CYC - 1)) begin
            st  <= S_OPEN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OPEN: begin
          if (cnt == CW'(ACC_CYC - 1)) begin
            st       <= S_ACT;
            row_q    <= lat_q[AW-1:ROW_LSB];
            rd_valid <= op[1];
            arr_we   <= op[0] & ~op[1];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAGE: begin
          if (cnt == CW'(PAGE_CYC - 1)) begin
            st       <= S_ACT;
            rd_valid <= op[1];
            arr_we   <= op[0] & ~op[1];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_CLOSED;
      endcase
    end
  end
endmodule

// File: rtl/row_precharge_ctrl_chk.sv
module row_precharge_ctrl_chk #(
  parameter int AW      = 17,
  parameter int ROW_LSB = 2,
  parameter int PRE_CYC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce_n,
  input logic [AW-1:0]       addr,
  input logic                ready,
  input logic                rd_valid,
  input logic                arr_we,
  input logic                row_closed,
  input logic                active,
  input logic [AW-1:ROW_LSB] row_q
);
  localparam int HW = $clog2(PRE_CYC + 1) + 1;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    hi_run <= '0;
    else if (!ce_n) hi_run <= '0;
    else if (hi_run < HW'(PRE_CYC)) hi_run <= hi_run + 1'b1;
  end

  assert_min_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) && row_closed |-> hi_run >= HW'(PRE_CYC));
  assert_ce_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active && ce_n |=> !ready);
  assert_row_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !ce_n && (addr[AW-1:ROW_LSB] != row_q) |=> !ready);
  assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_rvalid_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ready);
  assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);
  assert_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !rd_valid);
endmodule

bind row_precharge_ctrl row_precharge_ctrl_chk #(.AW(AW), .ROW_LSB(ROW_LSB), .PRE_CYC(PRE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr), .ready(ready),
  .rd_valid(rd_valid), .arr_we(arr_we), .row_closed(row_closed),
  .active(active), .row_q(row_q)
);

// File: tb/row_precharge_ctrl_bench.sv
module row_precharge_ctrl_bench;
  localparam int PRE_CYC = 4, ACC_CYC = 6, PAGE_CYC = 2;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ready, rd_valid, arr_we;
  logic [16:0] arr_addr;

  row_precharge_ctrl #(.PRE_CYC(PRE_CYC), .ACC_CYC(ACC_CYC), .PAGE_CYC(PAGE_CYC)) u_row_precharge_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr), .rd(rd), .wr(wr),
    .ready(ready), .rd_valid(rd_valid), .arr_we(arr_we), .arr_addr(arr_addr)
  );

  always #4 clk = ~clk;

  typedef struct { bit is_wr; int due; logic [16:0] a; logic [15:0] d; string tag; } item_t;
  item_t sb[$];
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  int cyc = 0, nchk = 0, nerr = 0, unexp = 0, open_row = -1;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_we) mem[int'(arr_addr)] = wdata;
  end

  function automatic logic [15:0] peek(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (a[15:0] ^ 16'h5A5A);
  endfunction

  function automatic logic [15:0] expv(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : (a[15:0] ^ 16'h5A5A);
  endfunction

  task automatic chk(input string tag, input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (rst_n && !done) begin
      if (rd_valid || arr_we) begin
        if (sb.size() == 0) begin
          unexp++;
          chk("R8 R9", 0, $sformatf("unexpected result rd_valid=%0b arr_we=%0b at cycle %0d, expected none",
              rd_valid, arr_we, cyc));
        end else begin
          it = sb.pop_front();
          chk(it.tag, (arr_we == it.is_wr) && (cyc == it.due) && (arr_addr == it.a) &&
              (it.is_wr || peek(arr_addr) == it.d),
              $sformatf("we=%0b cyc=%0d addr=%h data=%h, expected we=%0b cyc=%0d addr=%h data=%h",
              arr_we, cyc, arr_addr, peek(arr_addr), it.is_wr, it.due, it.a, it.d));
        end
      end else if (sb.size() > 0 && cyc > sb[0].due) begin
        it = sb.pop_front();
        chk(it.tag, 0, $sformatf("no result at cycle %0d, expected at cycle %0d", cyc, it.due));
      end
    end
  end

  task automatic access(input bit w, input logic [16:0] a, input logic [15:0] d,
                        input string tag, input bit stray);
    int lat;
    item_t it;
    while (!ready) @(negedge clk);
    if (open_row < 0) lat = ACC_CYC;
    else if (open_row != int'(a[16:2])) lat = PRE_CYC + ACC_CYC;
    else lat = PAGE_CYC;
    addr = a; ce_n = 1'b0; rd = !w; wr = w; wdata = d;
    it.is_wr = w; it.due = cyc + 1 + lat; it.a = a; it.d = w ? d : expv(a); it.tag = tag;
    sb.push_back(it);
    if (w) shadow[int'(a)] = d;
    open_row = int'(a[16:2]);
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    if (stray) begin
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
    end
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int u0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ready && !rd_valid && !arr_we,
        $sformatf("ready=%0b rd_valid=%0b arr_we=%0b, expected 1 0 0", ready, rd_valid, arr_we));

    access(0, 17'h00100, 16'h0, "R2", 0);
    access(0, 17'h00101, 16'h0, "R6", 0);
    access(0, 17'h00103, 16'h0, "R6", 0);
    access(1, 17'h00102, 16'hBEEF, "R7", 0);
    access(0, 17'h00102, 16'h0, "R9", 0);
    access(0, 17'h1C004, 16'h0, "R5", 0);
    access(1, 17'h04008, 16'h1234, "R7", 0);
    access(0, 17'h00102, 16'h0, "R5", 0);
    access(0, 17'h00106, 16'h0, "R5", 0);
    access(0, 17'h00105, 16'h0, "R6", 0);

    u0 = unexp;
    access(0, 17'h08000, 16'h0, "R8", 1);
    chk("R8", unexp == u0, $sformatf("extra results=%0d, expected 0", unexp - u0));

    ce_n = 1'b1;
    @(negedge clk);
    chk("R3", !ready, $sformatf("ready=%0b after enable rose, expected 0", ready));
    repeat (PRE_CYC - 2) @(negedge clk);
    chk("R3", !ready, $sformatf("ready=%0b one cycle before precharge end, expected 0", ready));
    @(negedge clk);
    chk("R3", ready, $sformatf("ready=%0b after full precharge, expected 1", ready));
    open_row = -1;
    access(0, 17'h04008, 16'h0, "R2", 0);

    ce_n = 1'b1;
    repeat (PRE_CYC - 2) @(negedge clk);
    ce_n = 1'b0; rd = 1'b1;
    repeat (8) @(negedge clk);
    rd = 1'b0;
    chk("R4", !ready, $sformatf("ready=%0b after short enable pulse, expected 0", ready));
    ce_n = 1'b1;
    repeat (PRE_CYC - 1) @(negedge clk);
    chk("R4", !ready, $sformatf("ready=%0b before full second precharge, expected 0", ready));
    @(negedge clk);
    chk("R4", ready, $sformatf("ready=%0b after full second precharge, expected 1", ready));
    chk("R8", unexp == u0, $sformatf("extra results=%0d during busy, expected 0", unexp - u0));
    open_row = -1;
    access(0, 17'h00102, 16'h0, "R2", 0);
    access(1, 17'h00101, 16'hA5C3, "R7", 0);
    access(0, 17'h00101, 16'h0, "R6", 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 100000);
    done = 1;
    chk("WATCHDOG", 0, "run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule